// File: doc/BRIEF.md
# Two-Way Time-Transfer Offset and Path-Delay Engine

This block sits on the slave side of a packet time-synchronisation link. Upstream logic parses the exchange messages and captures timestamps. It then presents each message to the engine as a single-cycle event. Each event carries a kind code, a sequence number, a two-step flag, a local timestamp and a remote timestamp. Every timestamp is a 48-bit seconds count paired with a 30-bit nanoseconds count.

The engine walks the exchange in its fixed order: Sync, then an optional Follow_Up, then Delay_Req, then Delay_Resp. It collects four instants:
- the master's Sync departure (t1);
- the local Sync arrival (t2);
- the local Delay_Req departure (t3);
- the master's Delay_Req arrival (t4), which the Delay_Resp returns.

For a two-step master, the engine holds t2 until a Follow_Up with the same sequence number supplies t1.

When a matching Delay_Resp arrives, the engine assumes the link is symmetric. It forms the master-to-slave interval (t2 − t1) and the slave-to-master interval (t4 − t3). It then reports the halved sum as the mean path delay and the halved difference as the slave-minus-master offset. Both are signed 64-bit nanosecond values, and they are qualified by a one-cycle strobe. The clock servo downstream consumes the strobe and the two values.

Top module: `tt_offset_engine`

## Requirements
- R1: After reset, `res_vld` is 0, both results are 0, and the engine waits for a Sync. A Delay_Req or Delay_Resp arriving before any Sync produces no result.
- R2: A Sync with `evt_two_step`=0 (kind code 0) supplies t2 on the local fields and t1 on the remote fields. Next, a Delay_Req (kind 2) supplies t3 on the local fields. A Delay_Resp (kind 3) with the Delay_Req's sequence number then supplies t4 on the remote fields and yields a result.
- R3: A Sync with `evt_two_step`=1 keeps t2 and waits. A Follow_Up (kind 1) whose sequence number equals the Sync's supplies t1 on the remote fields, and the exchange then continues as in R2.
- R4: `res_delay` equals ((t2 − t1) + (t4 − t3)) shifted right by one with the sign preserved. For example, a sum of −3 gives −2.
- R5: `res_offset` equals ((t2 − t1) − (t4 − t3)) shifted right by one with the sign preserved.
- R6: Each timestamp value is seconds × 1 000 000 000 + nanoseconds, with nanoseconds below 1e9. Intervals are exact across second boundaries and for gaps wider than 32 bits of nanoseconds.
- R7: A Follow_Up whose sequence number differs from the pending Sync's is discarded, and the engine returns to waiting for Sync. A later Delay_Req and Delay_Resp then produce no result.
- R8: A Delay_Resp whose sequence number differs from the pending Delay_Req's is discarded, produces no result, and returns the engine to waiting for Sync.
- R9: A Sync arriving in any state restarts the exchange with its own stamps and sequence number. The abandoned exchange no longer contributes.
- R10: `res_vld` is high for exactly one cycle, on the cycle after the clock edge that accepts the matching Delay_Resp. `res_offset` and `res_delay` hold their values until the next result.
- R11: An event whose kind is not the one expected in the current state is ignored, except Sync. Examples are a Follow_Up during a one-step exchange and a Delay_Resp while waiting for Delay_Req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_vld | input | 1 | Event present this cycle |
| evt_kind | input | 2 | 0 Sync, 1 Follow_Up, 2 Delay_Req, 3 Delay_Resp |
| evt_seq | input | SEQ_W | Message sequence number |
| evt_two_step | input | 1 | On Sync: t1 will follow in a Follow_Up |
| evt_loc_sec | input | 48 | Local stamp seconds (t2 on Sync, t3 on Delay_Req) |
| evt_loc_ns | input | 30 | Local stamp nanoseconds |
| evt_rem_sec | input | 48 | Remote stamp seconds (t1 on Sync/Follow_Up, t4 on Delay_Resp) |
| evt_rem_ns | input | 30 | Remote stamp nanoseconds |
| res_vld | output | 1 | One-cycle result strobe |
| res_offset | output | 64 | Signed slave-minus-master offset, ns |
| res_delay | output | 64 | Signed mean path delay, ns |

## Verification
A sequencer stuck in the wrong state shows up at the ports one cycle after the closing Delay_Resp. Either an expected strobe is missing, or a strobe appears after an exchange that should have been discarded. A stamp held in the wrong slot, or one overwritten by an ignored event, appears in the same strobe cycle as a wrong offset or delay. Sign or borrow faults in the arithmetic are exposed the same way, by exchanges with negative intervals, second-boundary crossings and odd sums.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int SEC_W = 48;
  localparam int NS_W  = 30;
  localparam int RES_W = 64;
  localparam int N_SLOT = 3;
  localparam int SLOT_T1 = 0;
  localparam int SLOT_T2 = 1;
  localparam int SLOT_T3 = 2;
  localparam logic signed [RES_W-1:0] NS_PER_SEC = 64'sd1000000000;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } stamp_t;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_WAIT_FU    = 2'd1,
    ST_WAIT_DREQ  = 2'd2,
    ST_WAIT_DRESP = 2'd3
  } state_t;

  localparam logic [1:0] K_SYNC   = 2'd0;
  localparam logic [1:0] K_FOLLOW = 2'd1;
  localparam logic [1:0] K_DREQ   = 2'd2;
  localparam logic [1:0] K_DRESP  = 2'd3;

  // a - b in signed nanoseconds, borrowing one second when ns underflows
  function automatic logic signed [RES_W-1:0] ts_diff(stamp_t a, stamp_t b);
    logic signed [RES_W-1:0] ds;
    logic signed [RES_W-1:0] dn;
    ds = signed'(RES_W'(a.sec)) - signed'(RES_W'(b.sec));
    dn = signed'(RES_W'(a.ns)) - signed'(RES_W'(b.ns));
    if (dn < 0) begin
      dn = dn + NS_PER_SEC;
      ds = ds - 64'sd1;
    end
    return ds * NS_PER_SEC + dn;
  endfunction

  // divide by two, rounding toward minus infinity, sign kept
  function automatic logic signed [RES_W-1:0] halve(logic signed [RES_W-1:0] v);
    return v >>> 1;
  endfunction
endpackage

// File: rtl/tt_seq_fsm.sv
module tt_seq_fsm #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_vld,
  input  logic [1:0]       evt_kind,
  input  logic [SEQ_W-1:0] evt_seq,
  input  logic             evt_two_step,
  output tt_pkg::state_t   state,
  output logic             ev_sync,
  output logic             ev_fu_ok,
  output logic             ev_fu_bad,
  output logic             ev_dreq,
  output logic             ev_dresp_ok,
  output logic             ev_dresp_bad,
  output logic [tt_pkg::N_SLOT-1:0] load
);
  import tt_pkg::*;

  state_t           state_q, state_d;
  logic [SEQ_W-1:0] sync_seq_q, dreq_seq_q;
  logic             ev_fu, ev_dresp;

  always_comb begin
    ev_sync      = evt_vld && (evt_kind == K_SYNC);
    ev_fu        = evt_vld && (evt_kind == K_FOLLOW) && (state_q == ST_WAIT_FU);
    ev_fu_ok     = ev_fu && (evt_seq == sync_seq_q);
    ev_fu_bad    = ev_fu && (evt_seq != sync_seq_q);
    ev_dreq      = evt_vld && (evt_kind == K_DREQ) && (state_q == ST_WAIT_DREQ);
    ev_dresp     = evt_vld && (evt_kind == K_DRESP) && (state_q == ST_WAIT_DRESP);
    ev_dresp_ok  = ev_dresp && (evt_seq == dreq_seq_q);
    ev_dresp_bad = ev_dresp && (evt_seq != dreq_seq_q);
  end

  always_comb begin
    state_d = state_q;
    if (ev_sync)
      state_d = evt_two_step ? ST_WAIT_FU : ST_WAIT_DREQ;
    else if (ev_fu_ok)
      state_d = ST_WAIT_DREQ;
    else if (ev_dreq)
      state_d = ST_WAIT_DRESP;
    else if (ev_fu_bad || ev_dresp)
      state_d = ST_IDLE;
  end

  always_comb begin
    load          = '0;
    load[SLOT_T1] = (ev_sync && !evt_two_step) || ev_fu_ok;
    load[SLOT_T2] = ev_sync;
    load[SLOT_T3] = ev_dreq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sync_seq_q <= '0;
      dreq_seq_q <= '0;
    end else begin
      state_q <= state_d;
      if (ev_sync) sync_seq_q <= evt_seq;
      if (ev_dreq) dreq_seq_q <= evt_seq;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/tt_stamp_store.sv
module tt_stamp_store (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [tt_pkg::N_SLOT-1:0]  load,
  input  tt_pkg::stamp_t             loc_stamp,
  input  tt_pkg::stamp_t             rem_stamp,
  output tt_pkg::stamp_t             t1,
  output tt_pkg::stamp_t             t2,
  output tt_pkg::stamp_t             t3
);
  import tt_pkg::*;

  stamp_t slot_q [N_SLOT];

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    // t1 is the master's stamp; t2 and t3 are local captures
    stamp_t src;
    assign src = (i == SLOT_T1) ? rem_stamp : loc_stamp;
    always_ff @(posedge clk) begin
      if (!rst_n)       slot_q[i] <= '0;
      else if (load[i]) slot_q[i] <= src;
    end
  end

  assign t1 = slot_q[SLOT_T1];
  assign t2 = slot_q[SLOT_T2];
  assign t3 = slot_q[SLOT_T3];
endmodule

// File: rtl/tt_delay_math.sv
module tt_delay_math (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                fire,
  input  tt_pkg::stamp_t                      t1,
  input  tt_pkg::stamp_t                      t2,
  input  tt_pkg::stamp_t                      t3,
  input  tt_pkg::stamp_t                      t4,
  output logic                                res_vld,
  output logic signed [tt_pkg::RES_W-1:0]     res_offset,
  output logic signed [tt_pkg::RES_W-1:0]     res_delay
);
  import tt_pkg::*;

  logic signed [RES_W-1:0] ms_ns, sm_ns, dly_d, off_d;

  always_comb begin
    ms_ns = ts_diff(t2, t1);
    sm_ns = ts_diff(t4, t3);
    dly_d = halve(ms_ns + sm_ns);
    off_d = halve(ms_ns - sm_ns);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld    <= 1'b0;
      res_offset <= '0;
      res_delay  <= '0;
    end else begin
      res_vld <= fire;
      if (fire) begin
        res_offset <= off_d;
        res_delay  <= dly_d;
      end
    end
  end
endmodule

// File: rtl/tt_offset_engine.sv
module tt_offset_engine #(
  parameter int SEQ_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             evt_vld,
  input  logic [1:0]                       evt_kind,
  input  logic [SEQ_W-1:0]                 evt_seq,
  input  logic                             evt_two_step,
  input  logic [tt_pkg::SEC_W-1:0]         evt_loc_sec,
  input  logic [tt_pkg::NS_W-1:0]          evt_loc_ns,
  input  logic [tt_pkg::SEC_W-1:0]         evt_rem_sec,
  input  logic [tt_pkg::NS_W-1:0]          evt_rem_ns,
  output logic                             res_vld,
  output logic signed [tt_pkg::RES_W-1:0]  res_offset,
  output logic signed [tt_pkg::RES_W-1:0]  res_delay
);
  import tt_pkg::*;

  state_t              state_q;
  logic                ev_sync, ev_fu_ok, ev_fu_bad, ev_dreq, ev_dresp_ok, ev_dresp_bad;
  logic [N_SLOT-1:0]   load;
  stamp_t              loc_stamp, rem_stamp, t1, t2, t3;

  assign loc_stamp = '{sec: evt_loc_sec, ns: evt_loc_ns};
  assign rem_stamp = '{sec: evt_rem_sec, ns: evt_rem_ns};

  tt_seq_fsm #(.SEQ_W(SEQ_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_vld      (evt_vld),
    .evt_kind     (evt_kind),
    .evt_seq      (evt_seq),
    .evt_two_step (evt_two_step),
    .state        (state_q),
    .ev_sync      (ev_sync),
    .ev_fu_ok     (ev_fu_ok),
    .ev_fu_bad    (ev_fu_bad),
    .ev_dreq      (ev_dreq),
    .ev_dresp_ok  (ev_dresp_ok),
    .ev_dresp_bad (ev_dresp_bad),
    .load         (load)
  );

  tt_stamp_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .loc_stamp (loc_stamp),
    .rem_stamp (rem_stamp),
    .t1        (t1),
    .t2        (t2),
    .t3        (t3)
  );

  // t4 comes straight from the Delay_Resp event in the accepting cycle
  tt_delay_math u_math (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (ev_dresp_ok),
    .t1         (t1),
    .t2         (t2),
    .t3         (t3),
    .t4         (rem_stamp),
    .res_vld    (res_vld),
    .res_offset (res_offset),
    .res_delay  (res_delay)
  );
endmodule

// File: rtl/tt_offset_engine_chk.sv
module tt_offset_engine_chk (
  input logic                              clk,
  input logic                              rst_n,
  input tt_pkg::state_t                    state,
  input logic                              evt_two_step,
  input logic                              ev_sync,
  input logic                              ev_fu_bad,
  input logic                              ev_dresp_ok,
  input logic                              ev_dresp_bad,
  input logic                              res_vld,
  input logic signed [tt_pkg::RES_W-1:0]   res_offset,
  input logic signed [tt_pkg::RES_W-1:0]   res_delay
);
  import tt_pkg::*;

  p_no_result_outside_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_WAIT_DRESP) |=> !res_vld);

  p_fu_mismatch_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fu_bad |=> (state == ST_IDLE) && !res_vld);

  p_resp_mismatch_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dresp_bad |=> (state == ST_IDLE) && !res_vld);

  p_sync_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |=> (state == ($past(evt_two_step) ? ST_WAIT_FU : ST_WAIT_DREQ)));

  p_strobe_follows_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dresp_ok |=> res_vld);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);

  p_results_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_dresp_ok |=> $stable(res_offset) && $stable(res_delay));
endmodule

bind tt_offset_engine tt_offset_engine_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state        (state_q),
  .evt_two_step (evt_two_step),
  .ev_sync      (ev_sync),
  .ev_fu_bad    (ev_fu_bad),
  .ev_dresp_ok  (ev_dresp_ok),
  .ev_dresp_bad (ev_dresp_bad),
  .res_vld      (res_vld),
  .res_offset   (res_offset),
  .res_delay    (res_delay)
);

// File: tb/tt_offset_engine_tb_top.sv
module tt_offset_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_vld = 1'b0;
  logic [1:0]  evt_kind = 2'd0;
  logic [15:0] evt_seq = '0;
  logic        evt_two_step = 1'b0;
  logic [47:0] evt_loc_sec = '0;
  logic [29:0] evt_loc_ns = '0;
  logic [47:0] evt_rem_sec = '0;
  logic [29:0] evt_rem_ns = '0;
  logic        res_vld;
  logic signed [63:0] res_offset, res_delay;

  always #5 clk = ~clk;

  tt_offset_engine #(.SEQ_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_kind(evt_kind),
    .evt_seq(evt_seq), .evt_two_step(evt_two_step),
    .evt_loc_sec(evt_loc_sec), .evt_loc_ns(evt_loc_ns),
    .evt_rem_sec(evt_rem_sec), .evt_rem_ns(evt_rem_ns),
    .res_vld(res_vld), .res_offset(res_offset), .res_delay(res_delay)
  );

  typedef struct {
    longint off;
    longint dly;
    int     due;
    string  tag;
  } exp_t;

  exp_t   exp_q[$];
  int     checks = 0;
  int     errors = 0;
  int     unexp  = 0;
  int     cyc    = 0;
  bit     prev_vld = 1'b0;
  bit     arm = 1'b0;
  exp_t   armed;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint tns(longint s, longint n);
    return s * 64'sd1000000000 + n;
  endfunction

  // monitor: pop the scoreboard whenever the design strobes a result
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_vld) begin
        if (prev_vld) begin
          checks++; errors++;
          $display("FAIL R10 strobe wider than one cycle: actual=2 cycles expected=1");
        end
        if (exp_q.size() == 0) begin
          unexp++;
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          checks++;
          if (res_offset !== e.off) begin
            errors++;
            $display("FAIL R5 %s offset actual=%0d expected=%0d", e.tag, res_offset, e.off);
          end
          checks++;
          if (res_delay !== e.dly) begin
            errors++;
            $display("FAIL R4 %s delay actual=%0d expected=%0d", e.tag, res_delay, e.dly);
          end
          checks++;
          if (cyc != e.due) begin
            errors++;
            $display("FAIL R10 %s strobe cycle actual=%0d expected=%0d", e.tag, cyc, e.due);
          end
        end
      end
      prev_vld = res_vld;
    end
  end

  task automatic send(input logic [1:0] kind, input int seq, input bit two,
                      input longint ls, input longint ln, input longint rs, input longint rn);
    @(negedge clk);
    evt_vld      = 1'b1;
    evt_kind     = kind;
    evt_seq      = 16'(seq);
    evt_two_step = two;
    evt_loc_sec  = 48'(ls);
    evt_loc_ns   = 30'(ln);
    evt_rem_sec  = 48'(rs);
    evt_rem_ns   = 30'(rn);
    if (arm) begin
      armed.due = cyc + 1;
      exp_q.push_back(armed);
      arm = 1'b0;
    end
    @(negedge clk);
    evt_vld = 1'b0;
  endtask

  // driver: full exchange, pushes the expected result before the Delay_Resp
  task automatic exchange(input bit two, input int sseq, input int dseq,
                          input longint t1s, input longint t1n, input longint t2s, input longint t2n,
                          input longint t3s, input longint t3n, input longint t4s, input longint t4n,
                          input string tag);
    longint ms, sm;
    ms = tns(t2s, t2n) - tns(t1s, t1n);
    sm = tns(t4s, t4n) - tns(t3s, t3n);
    send(2'd0, sseq, two, t2s, t2n, two ? 0 : t1s, two ? 0 : t1n);
    if (two) send(2'd1, sseq, 1'b0, 0, 0, t1s, t1n);
    send(2'd2, dseq, 1'b0, t3s, t3n, 0, 0);
    armed.off = (ms - sm) >>> 1;
    armed.dly = (ms + sm) >>> 1;
    armed.tag = tag;
    arm = 1'b1;
    send(2'd3, dseq, 1'b0, 0, 0, t4s, t4n);
  endtask

  task automatic expect_quiet(input string tag, input int snap);
    repeat (3) @(negedge clk);
    checks++;
    if (unexp != snap) begin
      errors++;
      $display("FAIL %s unexpected results actual=%0d expected=0", tag, unexp - snap);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    checks++;
    if (res_vld !== 1'b0 || res_offset !== 64'sd0 || res_delay !== 64'sd0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%0b/%0d/%0d expected=0/0/0", res_vld, res_offset, res_delay);
    end
    // R1 / R11: Delay_Req and Delay_Resp before any Sync
    snap = unexp;
    send(2'd2, 1, 1'b0, 10, 0, 0, 0);
    send(2'd3, 1, 1'b0, 0, 0, 10, 5);
    expect_quiet("R1", snap);

    // R2 one-step
    exchange(1'b0, 1, 1, 100, 500, 100, 1500, 100, 5000, 100, 5600, "R2 one-step");
    // R3 two-step, negative offset
    exchange(1'b1, 2, 2, 200, 0, 200, 900, 200, 2000, 200, 3300, "R3 two-step");
    // R6 borrow across second boundaries
    exchange(1'b0, 3, 3, 300, 999999900, 301, 50, 301, 999999990, 302, 20, "R6 borrow");
    // R4 arithmetic shift of negative odd sum
    exchange(1'b1, 4, 4, 400, 10, 400, 8, 400, 100, 400, 99, "R4 negative-odd");
    // R6 gaps wider than 32 bits
    exchange(1'b0, 5, 5, 1000, 0, 1005, 3, 1006, 0, 1001, 1, "R6 wide-gap");
    // R10 back-to-back exchanges
    exchange(1'b1, 6, 6, 50, 1, 50, 11, 50, 40, 50, 50, "R10 back-a");
    exchange(1'b0, 7, 7, 60, 7, 60, 27, 60, 90, 60, 94, "R10 back-b");

    // R7 Follow_Up with wrong sequence number
    snap = unexp;
    send(2'd0, 10, 1'b1, 700, 100, 0, 0);
    send(2'd1, 11, 1'b0, 0, 0, 700, 50);
    send(2'd2, 9, 1'b0, 700, 500, 0, 0);
    send(2'd3, 9, 1'b0, 0, 0, 700, 600);
    expect_quiet("R7", snap);

    // R8 Delay_Resp with wrong sequence number, then the right one too late
    snap = unexp;
    send(2'd0, 12, 1'b0, 800, 100, 800, 50);
    send(2'd2, 4, 1'b0, 800, 500, 0, 0);
    send(2'd3, 5, 1'b0, 0, 0, 800, 600);
    send(2'd3, 4, 1'b0, 0, 0, 800, 600);
    expect_quiet("R8", snap);

    // R9 new Sync abandons a pending two-step exchange; stale Follow_Up ignored (R11)
    send(2'd0, 20, 1'b1, 500, 100, 0, 0);
    send(2'd0, 21, 1'b0, 500, 800, 500, 300);
    send(2'd1, 20, 1'b0, 0, 0, 500, 50);
    send(2'd2, 3, 1'b0, 500, 2000, 0, 0);
    armed.off = (500 - 100) >>> 1;
    armed.dly = (500 + 100) >>> 1;
    armed.tag = "R9 restart";
    arm = 1'b1;
    send(2'd3, 3, 1'b0, 0, 0, 500, 2100);

    // R11 stray Follow_Up and Delay_Resp while waiting for Delay_Req
    send(2'd0, 30, 1'b0, 900, 1000, 900, 400);
    send(2'd1, 30, 1'b0, 0, 0, 900, 0);
    send(2'd3, 30, 1'b0, 0, 0, 900, 9);
    send(2'd2, 31, 1'b0, 900, 3000, 0, 0);
    armed.off = (600 - 200) >>> 1;
    armed.dly = (600 + 200) >>> 1;
    armed.tag = "R11 stray";
    arm = 1'b1;
    send(2'd3, 31, 1'b0, 0, 0, 900, 3200);

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || unexp != 0) begin
      errors++;
      $display("FAIL R10 scoreboard residue actual=%0d missing/%0d extra expected=0/0", exp_q.size(), unexp);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule